// File: doc/BRIEF.md
# Two's-Complement Last-Row Booth Selector

This combinational block produces the final partial-product row of a radix-4 Booth-recoded signed multiplier with an n-bit multiplicand. It takes the multiplicand and the last three-bit recoding window. It returns that row already in two's-complement form. A standard Booth row hands a separate negate bit to the reduction tree. This row has no such bit, so the tree that sums the rows is one row shorter.

The window is decoded into five mutually exclusive selects, one for each digit in {0, +1, +2, -1, -2}. The negated multiplicand comes from a parallel-prefix incrementer applied to the inverted operand, which is sign-extended by one bit beforehand. The doubled multiples are one-bit left shifts of the plain or negated operand. A masked four-way selector forms the row and gives all zeros when no non-zero select is active. The row is n+2 bits wide, which holds every multiple from -2X to +2X for any signed n-bit X.

Top module: `booth_tc_row`

## Requirements
- R1: The window `window[2:0]` (bit 2 is the most significant) maps to a digit as follows: 001 and 010 give +1, 011 gives +2, 100 gives -2, 101 and 110 give -1, and 000 and 111 give 0. Exactly one of the five internal selects is active for any known window.
- R2: For the digit -1 the row equals -X, sign-extended to n+2 bits. This holds for the most negative X (1 followed by zeros), where the row is +2^(n-1).
- R3: For the digits +2 and -2 the row equals 2X and -2X. For X = -2^(n-1) with digit -2 the row is +2^n.
- R4: For the digit 0 (windows 000 and 111) every bit of the row is zero, whatever the value of X.
- R5: For every X and every window, `row` read as a signed n+2-bit number equals digit times X. No extra correction bit is needed.
- R6: The block has no storage. A change on `mcand` or `window` shows on `row` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Signed multiplicand X |
| window | input | 3 | Last Booth recoding window; bit 2 is the most significant |
| row | output | WIDTH+2 | Signed partial-product row, digit times X |

## Verification
Two functions can act on the same evaluation: the prefix negation of the most negative operand, and the one-bit doubling shift. Together they produce the one result whose magnitude needs the full row width. The bench causes this by driving X = 100...0 with window 100. It also drives every other pairing of operand and window. Each result is judged against an integer product formed in the bench, and an undersized extension or a lost carry out of the top prefix bit shows up as a wrong sign or a wrong magnitude.

// File: rtl/btr_pkg.sv
package btr_pkg;

    // One-hot digit selects produced by the window decoder.
    typedef struct packed {
        logic neg2;
        logic neg1;
        logic pos2;
        logic pos1;
        logic zero;
    } digit_sel_t;

endpackage

// File: rtl/btr_window_decode.sv
module btr_window_decode
    import btr_pkg::*;
(
    input  logic [2:0]  win,
    output digit_sel_t  sel
);

    logic hi;
    logic mid;
    logic lo;

    assign hi  = win[2];
    assign mid = win[1];
    assign lo  = win[0];

    always_comb begin
        sel.pos1 = ~hi & (mid ^ lo);
        sel.pos2 = ~hi & mid & lo;
        sel.neg1 = hi & (mid ^ lo);
        sel.neg2 = hi & ~mid & ~lo;
        sel.zero = (hi & mid & lo) | (~hi & ~mid & ~lo);
    end

endmodule

// File: rtl/btr_prefix_negate.sv
module btr_prefix_negate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH:0]   neg
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] inv;
    logic [WIDTH-1:0] pre [0:LEVELS];

    assign inv    = ~val;
    assign pre[0] = inv;

    // Kogge-Stone AND prefix: after the last level, bit k holds AND of inv[k:0].
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int SH = 1 << l;
        localparam logic [WIDTH-1:0] LOWMASK =
            (SH >= WIDTH) ? {WIDTH{1'b1}} : ({WIDTH{1'b1}} >> (WIDTH - SH));
        assign pre[l+1] = pre[l] & ((pre[l] << SH) | LOWMASK);
    end

    // Carry into bit k is the AND of all inverted bits below k; carry into bit 0 is the +1.
    assign neg = {~val[WIDTH-1], inv} ^ {pre[LEVELS], 1'b1};

endmodule

// File: rtl/btr_row_select.sv
module btr_row_select
    import btr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  digit_sel_t        sel,
    input  logic [WIDTH-1:0]  x,
    input  logic [WIDTH:0]    nx,
    output logic [WIDTH+1:0]  row
);

    localparam int ROW_W = WIDTH + 2;

    logic [ROW_W-1:0] pos1_v;
    logic [ROW_W-1:0] pos2_v;
    logic [ROW_W-1:0] neg1_v;
    logic [ROW_W-1:0] neg2_v;
    logic             live;

    assign pos1_v = {{2{x[WIDTH-1]}}, x};
    assign pos2_v = {x[WIDTH-1], x, 1'b0};
    assign neg1_v = {nx[WIDTH], nx};
    assign neg2_v = {nx, 1'b0};
    assign live   = ~sel.zero;

    // Masked OR selector: no active select leaves every bit at zero.
    always_comb begin
        row = ({ROW_W{sel.pos1 & live}} & pos1_v)
            | ({ROW_W{sel.pos2 & live}} & pos2_v)
            | ({ROW_W{sel.neg1 & live}} & neg1_v)
            | ({ROW_W{sel.neg2 & live}} & neg2_v);
    end

endmodule

// File: rtl/booth_tc_row.sv
module booth_tc_row
    import btr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] mcand,
    input  logic [2:0]       window,
    output logic [WIDTH+1:0] row
);

    digit_sel_t       sel;
    logic [WIDTH:0]   neg_x;

    btr_window_decode u_dec (
        .win (window),
        .sel (sel)
    );

    btr_prefix_negate #(.WIDTH(WIDTH)) u_neg (
        .val (mcand),
        .neg (neg_x)
    );

    btr_row_select #(.WIDTH(WIDTH)) u_sel (
        .sel (sel),
        .x   (mcand),
        .nx  (neg_x),
        .row (row)
    );

endmodule

// File: rtl/booth_tc_row_chk.sv
module booth_tc_row_chk
    import btr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] mcand,
    input logic [2:0]       window,
    input digit_sel_t       sel,
    input logic [WIDTH:0]   neg_x,
    input logic [WIDTH+1:0] row
);

    logic [WIDTH:0] neg_sum;
    longint         digit;
    longint         want;

    always_comb begin
        neg_sum = neg_x + {mcand[WIDTH-1], mcand};
        digit   = sel.pos1 ? 64'sd1 : sel.pos2 ? 64'sd2 :
                  sel.neg1 ? -64'sd1 : sel.neg2 ? -64'sd2 : 64'sd0;
        want    = digit * longint'($signed(mcand));
        if (!$isunknown({mcand, window})) begin
            AST_SEL_ONE_HOT: assert ($onehot(sel)) else $error("select not one-hot"); // R1
            AST_DECODE_DOUBLE: assert ((window == 3'b011) == sel.pos2) else $error("double decode"); // R1
            AST_NEG_CANCELS: assert (neg_sum == '0) else $error("negation wrong"); // R2
            AST_ZERO_ROW: assert (!sel.zero || row == '0) else $error("zero row not clear"); // R4
            AST_ROW_PRODUCT: assert (longint'($signed(row)) == want) else $error("row mismatch"); // R5
        end
    end

endmodule

bind booth_tc_row booth_tc_row_chk #(.WIDTH(WIDTH)) u_chk (
    .mcand  (mcand),
    .window (window),
    .sel    (sel),
    .neg_x  (neg_x),
    .row    (row)
);

// File: tb/booth_tc_row_bench.sv
module booth_tc_row_bench;

    localparam int WIDTH      = 8;
    localparam int CLK_PERIOD = 10;
    localparam int XMIN       = -(1 << (WIDTH - 1));
    localparam int XMAX       = (1 << (WIDTH - 1)) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] mcand = '0;
    logic [2:0]       window = 3'b000;
    logic [WIDTH+1:0] row;
    int               checks = 0;
    int               fails  = 0;
    bit               done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_tc_row #(.WIDTH(WIDTH)) u_booth_tc_row (
        .mcand  (mcand),
        .window (window),
        .row    (row)
    );

    function automatic int ref_digit(input int w);
        case (w)
            1, 2:    return 1;
            3:       return 2;
            4:       return -2;
            5, 6:    return -1;
            default: return 0;
        endcase
    endfunction

    task automatic check_vec(input int xv, input int wv, input string tag);
        longint exp_v;
        longint got_v;
        exp_v = longint'(ref_digit(wv)) * longint'(xv);
        got_v = longint'($signed(row));
        checks++;
        if (got_v != exp_v) begin
            fails++;
            $display("FAIL %s x=%0d win=%03b got=%0d exp=%0d", tag, xv, wv[2:0], got_v, exp_v);
        end
    endtask

    function automatic string tag_for(input int xv, input int wv);
        int d;
        d = ref_digit(wv);
        if (d == 0) return "R4";
        if (d == 2 || d == -2) return "R3";
        if (d == -1 && xv == XMIN) return "R2";
        return "R1/R5";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_vec(0, 0, "R4 reset state");

        for (int xi = XMIN; xi <= XMAX; xi++) begin
            for (int wi = 0; wi < 8; wi++) begin
                @(posedge clk);
                #1;
                mcand  = WIDTH'(xi);
                window = 3'(wi);
                #1;
                check_vec(xi, wi, "R6 same cycle");
                @(negedge clk);
                check_vec(xi, wi, tag_for(xi, wi));
            end
        end

        // Corner: most negative operand, negate then double (R3, R2 together).
        @(posedge clk);
        #1;
        mcand  = WIDTH'(XMIN);
        window = 3'b100;
        @(negedge clk);
        check_vec(XMIN, 4, "R3 min operand doubled negate");

        // Zero windows leave the row clear for a busy operand (R4).
        @(posedge clk);
        #1;
        mcand  = WIDTH'(-1);
        window = 3'b111;
        @(negedge clk);
        check_vec(-1, 7, "R4 window 111");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R6 watchdog got=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule